// File: doc/BRIEF.md
# Five-Channel Timer Register Bank

This block is the software-visible register bank of a group of five down-counting timer channels. It sits behind a 32-bit word-addressed bus. For each channel it holds a control word and an initial-count word, and it drives both to the channel cores. It returns each channel's live count on reads. It collects every channel's expiry pulse into one shared status word, which software clears by writing ones. It drives one interrupt line per channel. The counting itself lives in the channel cores. They see this block only through the stored words, the live count inputs and the expiry pulses.

The register map is irregular. Channels 0 and 1 share a first bank, channels 2 and 3 share a second bank, and channel 4's registers sit alone at widely spaced offsets. A watchdog control word is also mapped. It only ever returns its reset constant.

Top module: `timer_bank`

## Requirements
- R1: Control words sit at 0x00, 0x04, 0x20, 0x24, 0x40 and initial-count words at 0x08, 0x0C, 0x28, 0x2C, 0x48, for channels 0 to 4 in that order. A write stores all 32 bits, and a read returns the stored word. The stored words drive `ctl_q` and `init_q`, with channel i in bits [32*i+31:32*i].
- R2: A read of 0x10, 0x14, 0x30, 0x34 or 0x50 returns the live count of channel 0, 1, 2, 3 or 4 respectively, taken from `cnt_now`.
- R3: An `expire[i]` pulse sets status bit i in the cycle after it. The status word reads at 0x18 with bits [4:0] holding the status and bits [31:5] reading zero.
- R4: A write to 0x18 clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R5: If an expiry and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: `irq[i]` is 1 exactly when bit 29 of channel i's control word and status bit i are both 1. It follows either of them one cycle after the write or expiry that changes it.
- R7: The live-count offsets are read-only. A write to them changes no stored word.
- R8: Offset 0x1C reads 0x00000400 at all times and ignores writes.
- R9: A read of an unmapped word offset, or of any address with bits [1:0] not zero, returns 0. A write to such an address changes nothing.
- R10: After reset every control word is 0x00000005, every initial-count word is 0 and the status word is 0. All `irq` lines are low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per asserted cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read access |
| cnt_now | input | 160 | Live count of each channel, 32 bits per channel |
| expire | input | 5 | One-cycle pulse when a channel reaches zero |
| ctl_q | output | 160 | Stored control word of each channel |
| init_q | output | 160 | Stored initial-count word of each channel |
| irq | output | 5 | Interrupt line per channel |

## Verification
A decode slip shows up on the next read of the affected offset. It also shows at once on the `ctl_q` or `init_q` slice of the wrong channel in the cycle after the write. A status bit that is wrongly set or wrongly cleared reaches the matching `irq` line one cycle after the expiry or write. Random interleavings of writes, reads and expiry pulses expose it whenever that channel's enable bit is on. When the enable bit is off, the error is exposed by the next status read. Coincident clear-and-expire cycles are driven on purpose, because only those cycles reveal a wrong priority.

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int          DW      = 32,
  parameter int          AW      = 12,
  parameter int          IE_BIT  = 29,
  parameter logic [31:0] CTL_RST = 32'h0000_0005,
  parameter logic [31:0] WDT_RST = 32'h0000_0400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [5*DW-1:0] cnt_now,
  input  logic [4:0]      expire,
  output logic [5*DW-1:0] ctl_q,
  output logic [5*DW-1:0] init_q,
  output logic [4:0]      irq
);
  localparam int NCH = 5;
  localparam int WW  = AW - 2;

  typedef enum logic [2:0] {K_NONE, K_CTL, K_INIT, K_CNT, K_STAT, K_WDT} kind_t;

  logic [DW-1:0] ctl  [NCH];
  logic [DW-1:0] init [NCH];
  logic [NCH-1:0] stat;

  kind_t        kind;
  logic [2:0]   ch;
  logic [WW-1:0] word;
  logic         aligned, wr_en, rd_en, wr_stat;

  assign word    = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_sel & bus_wr & aligned;
  assign rd_en   = bus_sel & ~bus_wr & aligned;
  assign wr_stat = wr_en & (kind == K_STAT);

  always_comb begin
    kind = K_NONE;
    ch   = 3'd0;
    case (word)
      WW'(0):  begin kind = K_CTL;  ch = 3'd0; end
      WW'(1):  begin kind = K_CTL;  ch = 3'd1; end
      WW'(2):  begin kind = K_INIT; ch = 3'd0; end
      WW'(3):  begin kind = K_INIT; ch = 3'd1; end
      WW'(4):  begin kind = K_CNT;  ch = 3'd0; end
      WW'(5):  begin kind = K_CNT;  ch = 3'd1; end
      WW'(6):  kind = K_STAT;
      WW'(7):  kind = K_WDT;
      WW'(8):  begin kind = K_CTL;  ch = 3'd2; end
      WW'(9):  begin kind = K_CTL;  ch = 3'd3; end
      WW'(10): begin kind = K_INIT; ch = 3'd2; end
      WW'(11): begin kind = K_INIT; ch = 3'd3; end
      WW'(12): begin kind = K_CNT;  ch = 3'd2; end
      WW'(13): begin kind = K_CNT;  ch = 3'd3; end
      WW'(16): begin kind = K_CTL;  ch = 3'd4; end
      WW'(18): begin kind = K_INIT; ch = 3'd4; end
      WW'(20): begin kind = K_CNT;  ch = 3'd4; end
      default: kind = K_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctl[i]  <= CTL_RST;
        init[i] <= '0;
      end
    end else if (wr_en) begin
      if (kind == K_CTL)  ctl[ch]  <= bus_wdata;
      if (kind == K_INIT) init[ch] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~(wr_stat ? bus_wdata[NCH-1:0] : '0)) | expire;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (kind)
        K_CTL:   bus_rdata = ctl[ch];
        K_INIT:  bus_rdata = init[ch];
        K_CNT:   bus_rdata = cnt_now[ch*DW +: DW];
        K_STAT:  bus_rdata = DW'(stat);
        K_WDT:   bus_rdata = WDT_RST;
        default: bus_rdata = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctl_q[g*DW +: DW]  = ctl[g];
    assign init_q[g*DW +: DW] = init[g];
    assign irq[g]             = ctl[g][IE_BIT] & stat[g];

    p_expire_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> stat[g]);
    p_clear_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[g] && !expire[g]) |=> !stat[g]);
    p_expire_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[g] && expire[g]) |=> irq[g] == ctl[g][IE_BIT]);
  end

  p_hold_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && expire == '0) |=> $stable(stat));
  p_count_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_CNT) |=> ($stable(ctl_q) && $stable(init_q)));
  p_irq_reset_r10: assert property (@(posedge clk) !rst_n |-> irq == '0);
endmodule

// File: tb/timer_bank_tb.sv
module timer_bank_tb_top;
  localparam int PERIOD = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [5*DW-1:0] cnt_now = '0, ctl_q, init_q;
  logic [4:0] expire = '0, irq;

  int checks = 0, errors = 0;
  logic [31:0] m_ctl [5];
  logic [31:0] m_init[5];
  logic [4:0]  m_stat;

  timer_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_now(cnt_now), .expire(expire), .ctl_q(ctl_q), .init_q(init_q), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a)
      12'h000: return m_ctl[0];  12'h004: return m_ctl[1];
      12'h020: return m_ctl[2];  12'h024: return m_ctl[3];
      12'h040: return m_ctl[4];
      12'h008: return m_init[0]; 12'h00C: return m_init[1];
      12'h028: return m_init[2]; 12'h02C: return m_init[3];
      12'h048: return m_init[4];
      12'h010: return cnt_now[0*DW +: DW]; 12'h014: return cnt_now[1*DW +: DW];
      12'h030: return cnt_now[2*DW +: DW]; 12'h034: return cnt_now[3*DW +: DW];
      12'h050: return cnt_now[4*DW +: DW];
      12'h018: return {27'd0, m_stat};
      12'h01C: return 32'h0000_0400;
      default: return '0;
    endcase
  endfunction

  function automatic logic [4:0] exp_irq();
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = m_ctl[i][29] & m_stat[i];
    return r;
  endfunction

  function automatic logic [11:0] pick_addr(int k);
    case (k)
      0: return 12'h000; 1: return 12'h004; 2: return 12'h008; 3: return 12'h00C;
      4: return 12'h010; 5: return 12'h014; 6: return 12'h018; 7: return 12'h01C;
      8: return 12'h020; 9: return 12'h024; 10: return 12'h028; 11: return 12'h02C;
      12: return 12'h030; 13: return 12'h034; 14: return 12'h040; 15: return 12'h048;
      16: return 12'h050; 17: return 12'h038; 18: return 12'h044; 19: return 12'h04C;
      20: return 12'h054; 21: return 12'hFFC; 22: return 12'h002; default: return 12'h041;
    endcase
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d, logic [4:0] ex);
    if (a[1:0] == 2'b00) begin
      case (a)
        12'h000: m_ctl[0] = d;  12'h004: m_ctl[1] = d;
        12'h020: m_ctl[2] = d;  12'h024: m_ctl[3] = d;
        12'h040: m_ctl[4] = d;
        12'h008: m_init[0] = d; 12'h00C: m_init[1] = d;
        12'h028: m_init[2] = d; 12'h02C: m_init[3] = d;
        12'h048: m_init[4] = d;
        12'h018: m_stat = m_stat & ~d[4:0];
        default: ;
      endcase
    end
    m_stat = m_stat | ex;
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d, logic [4:0] ex);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; expire = ex;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; expire = '0;
    model_write(a, d, ex);
  endtask

  task automatic do_pulse(logic [4:0] ex);
    @(negedge clk); expire = ex;
    @(negedge clk); expire = '0;
    m_stat = m_stat | ex;
  endtask

  task automatic do_read(string req, logic [11:0] a);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp_read(a));
    bus_sel = 0;
  endtask

  task automatic chk_outputs(string req);
    chk({req, " irq"}, {27'd0, irq}, {27'd0, exp_irq()});
    for (int i = 0; i < 5; i++) begin
      chk({req, " ctl_q"}, ctl_q[i*DW +: DW], m_ctl[i]);
      chk({req, " init_q"}, init_q[i*DW +: DW], m_init[i]);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < 5; i++) begin m_ctl[i] = 32'h5; m_init[i] = '0; end
    m_stat = '0;
    for (int i = 0; i < 5; i++) cnt_now[i*DW +: DW] = 32'hC000_0000 + i * 32'h111;

    // R10: reset values, irq low while reset is held, even with expiry pulses
    expire = 5'h1F;
    repeat (3) @(negedge clk);
    chk("R10 irq in reset", {27'd0, irq}, 32'd0);
    expire = '0;
    rst_n = 1;
    @(negedge clk);
    chk_outputs("R10");
    for (int k = 0; k < 24; k++) do_read("R10 reset read", pick_addr(k));

    // R1, R6: enable interrupt on channels 4 and 2
    do_write(12'h040, 32'h2000_0000, '0);
    do_write(12'h020, 32'h2000_00AB, '0);
    do_write(12'h048, 32'hDEAD_BEEF, '0);
    chk_outputs("R1");
    do_read("R1 ctl4", 12'h040);
    do_read("R1 init4", 12'h048);
    // R3, R6
    do_pulse(5'b10001);
    chk_outputs("R3 R6 after expiry");
    do_read("R3 status", 12'h018);
    // R4: zero bits leave status unchanged; one clears
    do_write(12'h018, 32'hFFFF_FFE0, '0);
    do_read("R4 zero write", 12'h018);
    do_write(12'h018, 32'h0000_0010, '0);
    chk_outputs("R4 clear");
    do_read("R4 status", 12'h018);
    // R5: expiry and clear collide on bit 0 and bit 4
    do_write(12'h018, 32'h0000_001F, 5'b10001);
    chk_outputs("R5 collision");
    do_read("R5 status", 12'h018);
    // R7, R8, R9
    do_write(12'h010, 32'h1234_5678, '0);
    do_write(12'h050, 32'h1234_5678, '0);
    chk_outputs("R7 count write");
    do_read("R2 count4", 12'h050);
    do_write(12'h01C, 32'h0, '0);
    do_read("R8 watchdog", 12'h01C);
    do_write(12'h002, 32'hFFFF_FFFF, '0);
    do_write(12'h044, 32'hFFFF_FFFF, '0);
    chk_outputs("R9 undefined write");
    do_read("R9 unaligned", 12'h042);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [11:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      a  = pick_addr($urandom_range(0, 23));
      d  = $urandom;
      if (op < 4) begin
        do_write(a, d, ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd0);
        chk_outputs("R1 R4 R5 R6 R7 R9 random write");
      end else if (op < 8) begin
        if ($urandom_range(0, 3) == 0)
          cnt_now[$urandom_range(0, 4)*DW +: DW] = $urandom;
        do_read("R1 R2 R3 R8 R9 random read", a);
      end else begin
        do_pulse(5'($urandom));
        chk_outputs("R3 R6 random expiry");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule